// File: doc/BRIEF.md
# Synchronous Burst SRAM With Clock-Enable Stall

A cycle-accurate model of a synchronous static memory of 256 words by 36 bits, split into four byte lanes of 9 bits. Every rising clock edge on which the stall input is low takes one command. The command comes from a load/continue control, a write select, three chip selects and an address. A loaded access starts a burst. Continue cycles repeat the type of the last loaded cycle on the next address of a four-word block.

Reads and writes share one fixed two-edge pipeline. Read data leaves an output register two enabled edges after its address. Write data and lane enables are taken two enabled edges after their address. A controller can therefore put reads and writes back to back with no idle cycles. The output is a data word plus a drive flag, not a tristate pin. Output enable and sleep gate the drive flag without a clock.

Top module: `sbs_burst_sram`

## Requirements
- R1: On an enabled edge (clk_hold low) with burst_go low, sel_a_n low, sel_b high, sel_c_n low and wr_n high, a read of addr starts. Its word is on rdata with rdata_oe high after the second enabled edge that follows, provided out_en_n and snooze are low.
- R2: The same load with wr_n low starts a write. wdata and lane_wr_n are sampled on the second enabled edge after the address edge.
- R3: Lane i is bits [9i+8:9i] and is written only when lane_wr_n[i] is low. When all lane_wr_n bits are high at the data edge, nothing is written and the stored word is unchanged.
- R4: An enabled edge with burst_go high repeats the type of the previous cycle. The address bits [1:0] increment modulo 4 and bits [7:2] stay unchanged, so a burst started at 0x3E visits 0x3E, 0x3F, 0x3C, 0x3D.
- R5: A load with sel_a_n high, sel_b low or sel_c_n high is a deselect. It yields rdata_oe low two edges later, and continue cycles after a deselect stay deselects.
- R6: A read whose output cycle sees out_en_n high keeps rdata_oe low. The burst address still advances.
- R7: An edge with clk_hold high changes no state. The command is ignored, rdata holds, and rdata_oe stays as it was (driven after a read, off during a write).
- R8: snooze high forces rdata_oe low at once, whatever the other inputs are.
- R9: rdata_oe is low in the output cycle of a write, even with out_en_n low.
- R10: After reset rdata_oe is low and the last cycle type is deselect, so continue cycles after reset do nothing.
- R11: A read issued one edge after a write to the same address returns the newly written bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| clk_hold | input | 1 | high: this edge is ignored (stall) |
| burst_go | input | 1 | high: continue burst; low: load new command |
| wr_n | input | 1 | low: write, high: read (on load) |
| lane_wr_n | input | 4 | per-lane write enable, active low, sampled with data |
| sel_a_n | input | 1 | chip select, active low |
| sel_b | input | 1 | chip select, active high |
| sel_c_n | input | 1 | chip select, active low |
| out_en_n | input | 1 | output enable, active low, unclocked |
| snooze | input | 1 | sleep, forces output off, unclocked |
| addr | input | 8 | word address |
| wdata | input | 36 | write data, sampled two enabled edges after its address |
| rdata | output | 36 | registered read data |
| rdata_oe | output | 1 | high when rdata would be driven |

## Verification
A command sampled on an enabled edge moves through two stages. Read data and the drive flag therefore change only right after the second enabled edge that follows, and write data belongs to that same edge. The bench drives inputs at the falling edge and samples outputs at the next falling edge. Its reference model advances one pipeline step per enabled edge and none on stalled edges, so every expected value lands on its due cycle even when stalls are inserted. out_en_n and snooze act without a clock and are checked in the cycle they are applied.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;
endpackage

// File: rtl/sbs_sequencer.sv
module sbs_sequencer
    import sbs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              burst_go,
    input  logic              wr_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic [ADDR_W-1:0] addr,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int PAGE_LO = BURST_W;

    typedef struct packed {
        op_e               last;
        logic [ADDR_W-1:0] ptr;
    } seq_t;

    seq_t seq_d, seq_q;
    logic chip_on;

    always_comb begin
        seq_d    = seq_q;
        chip_on  = !sel_a_n && sel_b && !sel_c_n;
        cmd_op   = OP_IDLE;
        cmd_addr = addr;
        if (!burst_go) begin
            if (chip_on) begin
                cmd_op = wr_n ? OP_RD : OP_WR;
            end
        end else begin
            cmd_op   = seq_q.last;
            cmd_addr = seq_q.ptr;
            if (seq_q.last != OP_IDLE) begin
                cmd_addr[BURST_W-1:0] = seq_q.ptr[BURST_W-1:0] + BURST_W'(1);
            end
        end
        if (!hold) begin
            seq_d.last = cmd_op;
            seq_d.ptr  = cmd_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.last <= OP_IDLE;
            seq_q.ptr  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    AST_DESEL_CONT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && burst_go && seq_q.last == OP_IDLE) |=> (seq_q.last == OP_IDLE)); // R5

    AST_BURST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && burst_go && seq_q.last != OP_IDLE) |=>
        (seq_q.ptr[ADDR_W-1:PAGE_LO] == $past(seq_q.ptr[ADDR_W-1:PAGE_LO]) &&
         seq_q.last == $past(seq_q.last))); // R4

    AST_HOLD_KEEPS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(seq_q)); // R7
endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_lane,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lane[g]) begin
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
    end
endmodule

// File: rtl/sbs_burst_sram.sv
module sbs_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_hold,
    input  logic                    burst_go,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    out_en_n,
    input  logic                    snooze,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    typedef struct packed {
        slot_t             s1;
        slot_t             s2;
        logic              drive;
        logic [DATA_W-1:0] rd;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LANES-1:0]  wr_lane;
    logic [DATA_W-1:0] arr_rdata;

    sbs_sequencer #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (clk_hold),
        .burst_go (burst_go),
        .wr_n     (wr_n),
        .sel_a_n  (sel_a_n),
        .sel_b    (sel_b),
        .sel_c_n  (sel_c_n),
        .addr     (addr),
        .cmd_op   (cmd_op),
        .cmd_addr (cmd_addr)
    );

    sbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_arr (
        .clk     (clk),
        .wr_lane (wr_lane),
        .wr_addr (pipe_q.s2.addr),
        .wr_data (wdata),
        .rd_addr (pipe_q.s2.addr),
        .rd_data (arr_rdata)
    );

    always_comb begin
        pipe_d  = pipe_q;
        wr_lane = '0;
        if (!clk_hold) begin
            pipe_d.s1.op   = cmd_op;
            pipe_d.s1.addr = cmd_addr;
            pipe_d.s2      = pipe_q.s1;
            if (pipe_q.s2.op == OP_RD) begin
                pipe_d.drive = 1'b1;
                pipe_d.rd    = arr_rdata;
            end else begin
                pipe_d.drive = 1'b0;
            end
            if (pipe_q.s2.op == OP_WR) begin
                wr_lane = ~lane_wr_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q.s1.op   <= OP_IDLE;
            pipe_q.s1.addr <= '0;
            pipe_q.s2.op   <= OP_IDLE;
            pipe_q.s2.addr <= '0;
            pipe_q.drive   <= 1'b0;
            pipe_q.rd      <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign rdata    = pipe_q.rd;
    assign rdata_oe = pipe_q.drive && !out_en_n && !snooze;

    AST_WRITE_MUTES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && pipe_q.s2.op == OP_WR) |=> !pipe_q.drive); // R9

    AST_IDLE_MUTES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && pipe_q.s2.op == OP_IDLE) |=> !pipe_q.drive); // R5

    AST_STALL_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        clk_hold |=> ($stable(rdata) && $stable(pipe_q.drive) && $stable(pipe_q.s2))); // R7

    AST_SNOOZE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |-> !rdata_oe); // R8
endmodule

// File: tb/test_sbs_burst_sram.sv
module test_sbs_burst_sram;
    localparam int AW = 8;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_hold, burst_go, wr_n, sel_a_n, sel_b, sel_c_n, out_en_n, snooze;
    logic [LN-1:0] lane_wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic          rdata_oe;

    always #5 clk = ~clk;

    sbs_burst_sram i_sbs_burst_sram (
        .clk(clk), .rst_n(rst_n), .clk_hold(clk_hold), .burst_go(burst_go),
        .wr_n(wr_n), .lane_wr_n(lane_wr_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .out_en_n(out_en_n), .snooze(snooze), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model: 0 idle, 1 read, 2 write
    logic [DW-1:0] mmem [256];
    int            m_last, p1_op, p2_op;
    logic [AW-1:0] m_ptr, p1_a, p2_a;
    logic          m_drive;
    logic [DW-1:0] m_rd;
    logic [DW-1:0] d0, d1, d2, d3, nw;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        int            op;
        logic [AW-1:0] a;
        if (p2_op == 2)
            for (int l = 0; l < LN; l++)
                if (!lane_wr_n[l]) mmem[p2_a][l*LW +: LW] = wdata[l*LW +: LW];
        if (p2_op == 1) begin
            m_drive = 1'b1;
            m_rd    = mmem[p2_a];
        end else begin
            m_drive = 1'b0;
        end
        p2_op = p1_op;
        p2_a  = p1_a;
        if (!burst_go) begin
            a  = addr;
            op = (!sel_a_n && sel_b && !sel_c_n) ? (wr_n ? 1 : 2) : 0;
        end else begin
            op = m_last;
            a  = m_ptr;
            if (op != 0) a[1:0] = m_ptr[1:0] + 2'd1;
        end
        m_last = op;
        m_ptr  = a;
        p1_op  = op;
        p1_a   = a;
    endtask

    task automatic step(input string tag, input logic h, input logic go, input logic wn,
                        input logic [LN-1:0] ln, input logic sa, input logic sb, input logic sc,
                        input logic oen, input logic sn, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd);
        logic exp_oe;
        clk_hold = h; burst_go = go; wr_n = wn; lane_wr_n = ln;
        sel_a_n = sa; sel_b = sb; sel_c_n = sc; out_en_n = oen; snooze = sn;
        addr = a; wdata = wd;
        @(posedge clk);
        if (!h) model_edge();
        @(negedge clk);
        exp_oe = m_drive && !oen && !sn;
        chk(tag, {63'd0, rdata_oe}, {63'd0, exp_oe});
        if (exp_oe) chk(tag, {28'd0, rdata}, {28'd0, m_rd});
    endtask

    task automatic ld_rd(input string t, input logic [AW-1:0] a, input logic oen);
        step(t, 0, 0, 1, '1, 0, 1, 0, oen, 0, a, '0);
    endtask
    task automatic ld_wr(input string t, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        step(t, 0, 0, 0, '0, 0, 1, 0, 0, 0, a, wd);
    endtask
    task automatic cont(input string t, input logic oen, input logic [LN-1:0] ln,
                        input logic [DW-1:0] wd);
        step(t, 0, 1, 1, ln, 0, 1, 0, oen, 0, 8'h00, wd);
    endtask
    task automatic desel(input string t, input logic oen, input logic [LN-1:0] ln,
                         input logic [DW-1:0] wd);
        step(t, 0, 0, 1, ln, 1, 1, 0, oen, 0, 8'h55, wd);
    endtask

    function automatic logic [DW-1:0] rnd_word();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[DW-1:0];
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_last = 0; p1_op = 0; p2_op = 0; m_ptr = '0; p1_a = '0; p2_a = '0;
        m_drive = 1'b0; m_rd = '0;
        rst_n = 1'b0; clk_hold = 0; burst_go = 0; wr_n = 1; lane_wr_n = '1;
        sel_a_n = 1; sel_b = 1; sel_c_n = 0; out_en_n = 0; snooze = 0;
        addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R10", {63'd0, rdata_oe}, 64'd0);
        // continue cycles right after reset stay deselects
        cont("R10", 0, '0, '0);
        cont("R10", 0, '0, '0);
        cont("R10", 0, '0, '0);

        // fill the whole array with four-word write bursts (R2, R4, R9)
        for (int i = 0; i < 64; i++) begin
            ld_wr("R2", 8'(i * 4), rnd_word());
            for (int k = 0; k < 3; k++) cont("R9", 0, '0, rnd_word());
        end
        desel("R2", 0, '0, rnd_word());
        desel("R2", 0, '0, rnd_word());

        // wrapping write burst from 0x3E
        d0 = rnd_word(); d1 = rnd_word(); d2 = rnd_word(); d3 = rnd_word();
        ld_wr("R4", 8'h3E, '0);
        cont("R4", 0, '0, '0);
        cont("R4", 0, '0, d0);
        cont("R4", 0, '0, d1);
        desel("R4", 0, '0, d2);
        desel("R4", 0, '0, d3);
        ld_rd("R1", 8'h3C, 0);
        desel("R1", 0, '1, '0);
        desel("R1", 0, '1, '0);
        chk("R4", {28'd0, rdata}, {28'd0, d2});

        // write abort leaves 0x3C, partial lanes on 0x3D
        nw = rnd_word();
        ld_wr("R3", 8'h3C, '0);
        ld_wr("R3", 8'h3D, '0);
        desel("R3", 0, 4'b1111, nw);
        desel("R3", 0, 4'b1010, nw);
        ld_rd("R3", 8'h3C, 0);
        ld_rd("R3", 8'h3D, 0);
        desel("R3", 0, '1, '0);
        chk("R3", {28'd0, rdata}, {28'd0, d2});
        desel("R3", 0, '1, '0);
        chk("R3", {28'd0, rdata}, {28'd0, d3[35:27], nw[26:18], d3[17:9], nw[8:0]});

        // dummy read: first two outputs hidden, address still advances
        ld_rd("R6", 8'h3C, 1);
        cont("R6", 1, '1, '0);
        cont("R6", 1, '1, '0);
        cont("R6", 1, '1, '0);
        desel("R6", 0, '1, '0);
        desel("R6", 0, '1, '0);
        chk("R6", {28'd0, rdata}, {28'd0, d1});

        // read directly after write to the same address
        nw = rnd_word();
        ld_wr("R11", 8'h40, '0);
        ld_rd("R11", 8'h40, 0);
        desel("R11", 0, '0, nw);
        desel("R11", 0, '1, '0);
        chk("R11", {28'd0, rdata}, {28'd0, nw});

        // stall while read data is driven and while a read is in flight
        ld_rd("R7", 8'h3C, 0);
        desel("R7", 0, '1, '0);
        desel("R7", 0, '1, '0);
        for (int k = 0; k < 3; k++) step("R7", 1, 0, 0, '0, 0, 1, 0, 0, 0, 8'(k), '0);
        chk("R7", {28'd0, rdata}, {28'd0, d2});
        ld_rd("R7", 8'h3D, 0);
        step("R7", 1, 1, 0, '0, 0, 1, 0, 0, 0, 8'h00, '0);
        desel("R7", 0, '1, '0);
        step("R7", 1, 0, 0, '0, 1, 0, 1, 0, 0, 8'h11, '0);
        desel("R7", 0, '1, '0);

        // stall during a write keeps output off
        ld_wr("R9", 8'h80, '0);
        desel("R9", 0, '1, '0);
        step("R9", 1, 0, 1, '1, 0, 1, 0, 0, 0, 8'h80, '0);
        desel("R9", 0, '0, rnd_word());
        chk("R9", {63'd0, rdata_oe}, 64'd0);

        // each chip select alone deselects; continue after deselect idles
        ld_rd("R5", 8'h3C, 0);
        step("R5", 0, 0, 1, '1, 1, 1, 0, 0, 0, 8'h3C, '0);
        step("R5", 0, 0, 1, '1, 0, 0, 0, 0, 0, 8'h3C, '0);
        step("R5", 0, 0, 1, '1, 0, 1, 1, 0, 0, 8'h3C, '0);
        cont("R5", 0, '1, '0);
        cont("R5", 0, '1, '0);
        chk("R5", {63'd0, rdata_oe}, 64'd0);

        // snooze during a driven output
        ld_rd("R8", 8'h3D, 0);
        desel("R8", 0, '1, '0);
        step("R8", 0, 0, 1, '1, 1, 1, 0, 0, 1, 8'h00, '0);
        chk("R8", {63'd0, rdata_oe}, 64'd0);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic h, go, wn, sa, sb, sc, oen, sn;
            h   = ($urandom_range(0, 9) == 0);
            go  = ($urandom_range(0, 9) < 4);
            wn  = $urandom_range(0, 1);
            sa  = ($urandom_range(0, 9) == 0);
            sb  = ($urandom_range(0, 9) != 0);
            sc  = ($urandom_range(0, 9) == 0);
            oen = ($urandom_range(0, 7) == 0);
            sn  = ($urandom_range(0, 19) == 0);
            step("R1", h, go, wn, 4'($urandom_range(0, 15)), sa, sb, sc, oen, sn,
                 8'($urandom_range(0, 255)), rnd_word());
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule